// File: doc/BRIEF.md
# Melody Sequencer Tone Generator

This block plays a tune that is stored as a list of note words. It runs from a 32.768 kHz clock. Software fills a writable melody array of 80 byte-wide words and a writable 16-entry pitch table. It then writes a start address, which begins playback at once. Each note word picks a pitch-table entry and a length code. The pitch entry holds a half-period count, and a divider turns that count into a square wave. The length code sets how many tempo ticks the note lasts.

A tempo prescaler makes the tick. Its period comes from one of two base tempo settings, and that period can be divided by 8, 16 or 32 for fast play. A note word can mark itself as the final note of its tune. When the final note ends with repeat off, playback stops and a one-cycle completion interrupt fires. With repeat on, playback returns to the start address and keeps going. A stop command ends playback without an interrupt. Writing a new start address while a tune plays drops the current tune and begins the new one.

Top module: `melody_sequencer`

## Requirements
- R1: After reset, toneOut is 0, toneOutN is 1, playing is 0 and doneIrq is 0.
- R2: A melody word is decoded as follows: bits [3:0] are the pitch-table index, bits [6:4] are the length code, and bit 7 set marks the final note of a tune.
- R3: A note lasts (code+1) tempo ticks. A tick lasts TICK_A clocks when tempoSel is 0 and TICK_B clocks when tempoSel is 1. That count is divided by 1, 8, 16 or 32 for speedSel values 0, 1, 2 and 3.
- R4: On a pitched note, toneOut is a square wave that starts low in the first cycle of the note and toggles every H clocks. H is the pitch entry itself when HIGH_RANGE is 1, and twice the entry when HIGH_RANGE is 0 (the default, one octave lower).
- R5: The pitch index 15 is a rest. During a rest, toneOut stays 0 and toneOutN stays 1 for the whole length of the note.
- R6: toneOutN is always the inverse of toneOut.
- R7: When startWr is sampled high, playing is 1 in the next cycle and the note at startAddr begins in that cycle. A startAddr of 80 or more starts at address 0.
- R8: When a note that is not a final note ends, the next address plays. Address 79 is followed by address 0.
- R9: When a final note ends with repeatEn low, playing drops and doneIrq is high for exactly that one cycle.
- R10: When a final note ends with repeatEn high, playback continues from the last start address and doneIrq stays low.
- R11: A startWr during playback abandons the current note in the same cycle and begins the new tune.
- R12: stopCmd without startWr ends playback in the next cycle without raising doneIrq, and has no effect while idle. startWr takes priority over stopCmd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| melWrEn | input | 1 | Melody array write enable |
| melWrAddr | input | 7 | Melody array write address (80 and above ignored) |
| melWrData | input | 8 | Melody word to write |
| pitchWrEn | input | 1 | Pitch table write enable |
| pitchWrAddr | input | 4 | Pitch table write index |
| pitchWrData | input | 8 | Half-period count to write |
| startWr | input | 1 | Start address strobe; begins or replaces a tune |
| startAddr | input | 7 | First melody address of the tune |
| stopCmd | input | 1 | Ends playback |
| repeatEn | input | 1 | Loop back to the start address at the final note |
| tempoSel | input | 1 | Base tempo choice (0: TICK_A, 1: TICK_B) |
| speedSel | input | 2 | Tempo speed-up: x1, x8, x16, x32 |
| toneOut | output | 1 | Square-wave tone |
| toneOutN | output | 1 | Inverse of toneOut |
| playing | output | 1 | A tune is in progress |
| doneIrq | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked on every cycle. The melody address always stays inside the array. The completion pulse lasts one cycle, appears only as playback drops, and never appears while repeat is on. A start strobe always leaves the block playing, and a stop without a start always leaves it idle. Other behaviours can only be seen through the bench's scenarios, where a reference model predicts the tone waveform cycle by cycle. These are the exact note lengths under each tempo and speed setting, the tone half-periods, rests, the wrap from address 79 to 0, looping in repeat mode, and a forced restart in the middle of a note.

// File: rtl/mel_pkg.sv
package mel_pkg;
  // Strobes from the sequencing control to the datapath.
  typedef struct packed {
    logic noteStart;  // reset note counters this edge
    logic active;     // a tune is in progress
  } mel_strobe_t;

  localparam int unsigned WORD_W = 8;
  localparam int unsigned PITCH_ENTRIES = 16;
  localparam int unsigned CODE_W = 3;
endpackage

// File: rtl/mel_ctrl.sv
module mel_ctrl
  import mel_pkg::*;
#(
  parameter int unsigned MEL_DEPTH = 80,
  parameter int unsigned ADDR_W = $clog2(MEL_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startWr,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              stopCmd,
  input  logic              repeatEn,
  input  logic              noteEnd,
  input  logic              lastNote,
  output mel_strobe_t       strb,
  output logic [ADDR_W-1:0] addr,
  output logic              doneIrq
);
  logic              playing;
  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] startClamped;
  logic [ADDR_W-1:0] nextAddr;
  logic              goNext;
  logic              finish;

  always_comb begin
    startClamped   = (int'(startAddr) < MEL_DEPTH) ? startAddr : '0;
    goNext         = playing && noteEnd && (!lastNote || repeatEn);
    finish         = playing && noteEnd && lastNote && !repeatEn;
    strb.active    = playing;
    strb.noteStart = startWr || (goNext && !stopCmd);
    if (lastNote)                         nextAddr = baseAddr;
    else if (int'(addr) == MEL_DEPTH - 1) nextAddr = '0;
    else                                  nextAddr = addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      playing  <= 1'b0;
      addr     <= '0;
      baseAddr <= '0;
      doneIrq  <= 1'b0;
    end else begin
      doneIrq <= 1'b0;
      if (startWr) begin
        playing  <= 1'b1;
        addr     <= startClamped;
        baseAddr <= startClamped;
      end else if (playing && stopCmd) begin
        playing <= 1'b0;
      end else if (goNext) begin
        addr <= nextAddr;
      end else if (finish) begin
        playing <= 1'b0;
        doneIrq <= 1'b1;
      end
    end
  end

  a_r8_addr_in_range: assert property (@(posedge clk) disable iff (!rstN)
    int'(addr) < MEL_DEPTH);
  a_r9_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);
  a_r9_irq_idle: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> !playing);
  a_r10_repeat_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (playing && repeatEn) |=> !doneIrq);
  a_r7_start_plays: assert property (@(posedge clk) disable iff (!rstN)
    startWr |=> playing);
  a_r12_stop_halts: assert property (@(posedge clk) disable iff (!rstN)
    (stopCmd && !startWr) |=> !playing);
endmodule

// File: rtl/mel_datapath.sv
module mel_datapath
  import mel_pkg::*;
#(
  parameter int unsigned MEL_DEPTH = 80,
  parameter int unsigned ADDR_W = $clog2(MEL_DEPTH + 1),
  parameter int unsigned PITCH_W = 8,
  parameter int unsigned TICK_A = 4096,
  parameter int unsigned TICK_B = 8192,
  parameter bit          HIGH_RANGE = 1'b0,
  parameter int unsigned REST_IDX = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               melWrEn,
  input  logic [ADDR_W-1:0]  melWrAddr,
  input  logic [WORD_W-1:0]  melWrData,
  input  logic               pitchWrEn,
  input  logic [3:0]         pitchWrAddr,
  input  logic [PITCH_W-1:0] pitchWrData,
  input  logic               tempoSel,
  input  logic [1:0]         speedSel,
  input  mel_strobe_t        strb,
  input  logic [ADDR_W-1:0]  addr,
  output logic               noteEnd,
  output logic               lastNote,
  output logic               toneOut
);
  localparam int unsigned TICK_MAX = (TICK_A > TICK_B) ? TICK_A : TICK_B;
  localparam int unsigned TICK_W   = $clog2(TICK_MAX + 1);
  localparam int unsigned HALF_W   = PITCH_W + 1;

  logic [WORD_W-1:0]  melMem   [MEL_DEPTH];
  logic [PITCH_W-1:0] pitchMem [PITCH_ENTRIES];

  logic [WORD_W-1:0]  word;
  logic [3:0]         noteIdx;
  logic [CODE_W-1:0]  noteCode;
  logic [TICK_W-1:0]  basePeriod;
  logic [TICK_W-1:0]  tickPeriod;
  logic [TICK_W-1:0]  preCnt;
  logic [CODE_W-1:0]  elapsed;
  logic               tick;
  logic [HALF_W-1:0]  halfPer;
  logic [HALF_W-1:0]  halfLim;
  logic [HALF_W-1:0]  toneCnt;
  logic               toneReg;

  // Writable arrays
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEL_DEPTH; i++) melMem[i] <= '0;
    end else if (melWrEn && int'(melWrAddr) < MEL_DEPTH) begin
      melMem[melWrAddr] <= melWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PITCH_ENTRIES; i++) pitchMem[i] <= PITCH_W'(i + 1);
    end else if (pitchWrEn) begin
      pitchMem[pitchWrAddr] <= pitchWrData;
    end
  end

  // Decode and tempo selection
  always_comb begin
    word       = melMem[addr];
    noteIdx    = word[3:0];
    noteCode   = word[6:4];
    lastNote   = word[7];
    basePeriod = tempoSel ? TICK_W'(TICK_B) : TICK_W'(TICK_A);
    case (speedSel)
      2'd0:    tickPeriod = basePeriod;
      2'd1:    tickPeriod = basePeriod >> 3;
      2'd2:    tickPeriod = basePeriod >> 4;
      default: tickPeriod = basePeriod >> 5;
    endcase
    tick    = strb.active && (preCnt >= tickPeriod - TICK_W'(1));
    noteEnd = tick && (elapsed == noteCode);
  end

  generate
    if (HIGH_RANGE) begin : g_high
      assign halfPer = {1'b0, pitchMem[noteIdx]};
    end else begin : g_low
      assign halfPer = {pitchMem[noteIdx], 1'b0};
    end
  endgenerate

  assign halfLim = (halfPer == '0) ? '0 : halfPer - HALF_W'(1);

  // Prescaler, duration counter and tone divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      elapsed <= '0;
      toneCnt <= '0;
      toneReg <= 1'b0;
    end else if (strb.noteStart) begin
      preCnt  <= '0;
      elapsed <= '0;
      toneCnt <= '0;
      toneReg <= 1'b0;
    end else if (strb.active) begin
      if (tick) begin
        preCnt  <= '0;
        elapsed <= elapsed + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
      if (toneCnt >= halfLim) begin
        toneCnt <= '0;
        toneReg <= ~toneReg;
      end else begin
        toneCnt <= toneCnt + 1'b1;
      end
    end
  end

  assign toneOut = toneReg && strb.active && (int'(noteIdx) != REST_IDX);

  a_r3_elapsed_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && !strb.noteStart && tick && !noteEnd) |=> (elapsed != '0));
endmodule

// File: rtl/melody_sequencer.sv
module melody_sequencer
  import mel_pkg::*;
#(
  parameter int unsigned MEL_DEPTH = 80,
  parameter int unsigned PITCH_W = 8,
  parameter int unsigned TICK_A = 4096,
  parameter int unsigned TICK_B = 8192,
  parameter bit          HIGH_RANGE = 1'b0,
  parameter int unsigned REST_IDX = 15,
  parameter int unsigned ADDR_W = $clog2(MEL_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               melWrEn,
  input  logic [ADDR_W-1:0]  melWrAddr,
  input  logic [7:0]         melWrData,
  input  logic               pitchWrEn,
  input  logic [3:0]         pitchWrAddr,
  input  logic [PITCH_W-1:0] pitchWrData,
  input  logic               startWr,
  input  logic [ADDR_W-1:0]  startAddr,
  input  logic               stopCmd,
  input  logic               repeatEn,
  input  logic               tempoSel,
  input  logic [1:0]         speedSel,
  output logic               toneOut,
  output logic               toneOutN,
  output logic               playing,
  output logic               doneIrq
);
  mel_strobe_t       strb;
  logic [ADDR_W-1:0] addr;
  logic              noteEnd;
  logic              lastNote;

  mel_ctrl #(.MEL_DEPTH(MEL_DEPTH), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .startWr(startWr), .startAddr(startAddr),
    .stopCmd(stopCmd), .repeatEn(repeatEn), .noteEnd(noteEnd),
    .lastNote(lastNote), .strb(strb), .addr(addr), .doneIrq(doneIrq)
  );

  mel_datapath #(
    .MEL_DEPTH(MEL_DEPTH), .ADDR_W(ADDR_W), .PITCH_W(PITCH_W),
    .TICK_A(TICK_A), .TICK_B(TICK_B), .HIGH_RANGE(HIGH_RANGE),
    .REST_IDX(REST_IDX)
  ) i_dp (
    .clk(clk), .rstN(rstN), .melWrEn(melWrEn), .melWrAddr(melWrAddr),
    .melWrData(melWrData), .pitchWrEn(pitchWrEn), .pitchWrAddr(pitchWrAddr),
    .pitchWrData(pitchWrData), .tempoSel(tempoSel), .speedSel(speedSel),
    .strb(strb), .addr(addr), .noteEnd(noteEnd), .lastNote(lastNote),
    .toneOut(toneOut)
  );

  assign toneOutN = ~toneOut;
  assign playing  = strb.active;
endmodule

// File: tb/test_melody_sequencer.sv
module test_melody_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int TA = 64;
  localparam int TB = 96;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       melWrEn = 1'b0;
  logic [6:0] melWrAddr = '0;
  logic [7:0] melWrData = '0;
  logic       pitchWrEn = 1'b0;
  logic [3:0] pitchWrAddr = '0;
  logic [7:0] pitchWrData = '0;
  logic       startWr = 1'b0;
  logic [6:0] startAddr = '0;
  logic       stopCmd = 1'b0;
  logic       repeatEn = 1'b0;
  logic       tempoSel = 1'b0;
  logic [1:0] speedSel = 2'd1;
  logic       toneOut, toneOutN, playing, doneIrq;

  melody_sequencer #(.TICK_A(TA), .TICK_B(TB)) i_melody_sequencer (
    .clk(clk), .rstN(rstN), .melWrEn(melWrEn), .melWrAddr(melWrAddr),
    .melWrData(melWrData), .pitchWrEn(pitchWrEn), .pitchWrAddr(pitchWrAddr),
    .pitchWrData(pitchWrData), .startWr(startWr), .startAddr(startAddr),
    .stopCmd(stopCmd), .repeatEn(repeatEn), .tempoSel(tempoSel),
    .speedSel(speedSel), .toneOut(toneOut), .toneOutN(toneOutN),
    .playing(playing), .doneIrq(doneIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit    tone;
    bit    play;
    bit    irq;
    string tag;
  } exp_t;

  exp_t q[$];
  int compared = 0;
  int mismatched = 0;
  int benchMel [80];
  int benchPitch [16];

  // Monitor: pops one expected item per cycle, just after each edge.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compared++;
      if (toneOut !== e.tone || playing !== e.play || doneIrq !== e.irq) begin
        mismatched++;
        $display("FAIL %s: tone/play/irq actual %b%b%b expected %b%b%b at %0t",
                 e.tag, toneOut, playing, doneIrq, e.tone, e.play, e.irq, $time);
      end
      compared++;
      if (toneOutN !== ~toneOut) begin  // R6
        mismatched++;
        $display("FAIL R6: toneOutN actual %b expected %b", toneOutN, ~toneOut);
      end
    end
  end

  function automatic int tickLen();
    int base = tempoSel ? TB : TA;
    case (speedSel)
      2'd0: return base;
      2'd1: return base >> 3;
      2'd2: return base >> 4;
      default: return base >> 5;
    endcase
  endfunction

  task automatic pushIdle(input int n, input string tag, input bit firstIrq);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.tone = 0; e.play = 0; e.irq = (k == 0) && firstIrq; e.tag = tag;
      q.push_back(e);
    end
  endtask

  // Reference model of one tune from the requirements.
  task automatic pushTune(input int sa, input int n, input string tag);
    int a = (sa < 80) ? sa : 0;
    int base = a;
    int k = 0;
    int p = tickLen();
    while (k < n) begin
      int w = benchMel[a];
      int idx = w & 15;
      int code = (w >> 4) & 7;
      bit last = (w >> 7) & 1;
      int len = (code + 1) * p;
      int h = 2 * benchPitch[idx];
      for (int j = 0; j < len && k < n; j++) begin
        exp_t e;
        e.tone = (idx != 15) && (((j / h) % 2) == 1);
        e.play = 1; e.irq = 0; e.tag = tag;
        q.push_back(e);
        k++;
      end
      if (k < n) begin
        if (last && !repeatEn) begin
          pushIdle(n - k, tag, 1'b1);
          k = n;
        end else if (last) begin
          a = base;
        end else begin
          a = (a == 79) ? 0 : a + 1;
        end
      end
    end
  endtask

  task automatic startTune(input int sa, input int n, input string tag);
    startWr = 1'b1;
    startAddr = 7'(sa);
    pushTune(sa, n, tag);
    @(negedge clk);
    startWr = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic stopFor(input int n, input string tag);
    stopCmd = 1'b1;
    pushIdle(n, tag, 1'b0);
    @(negedge clk);
    stopCmd = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic idleFor(input int n, input string tag);
    pushIdle(n, tag, 1'b0);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeMel(input int a, input int d);
    melWrEn = 1'b1; melWrAddr = 7'(a); melWrData = 8'(d);
    if (a < 80) benchMel[a] = d;
    @(negedge clk);
    melWrEn = 1'b0;
  endtask

  task automatic writePitch(input int a, input int d);
    pitchWrEn = 1'b1; pitchWrAddr = 4'(a); pitchWrData = 8'(d);
    benchPitch[a] = d;
    @(negedge clk);
    pitchWrEn = 1'b0;
  endtask

  function automatic int nw(input int last, input int code, input int idx);
    return (last << 7) | (code << 4) | idx;
  endfunction

  initial begin
    for (int i = 0; i < 80; i++) benchMel[i] = 0;
    for (int i = 0; i < 16; i++) benchPitch[i] = i + 1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    idleFor(5, "R1");
    for (int i = 0; i < 16; i++) writePitch(i, 2 + (i % 4));
    // R2 field layout: tune at 5 mixes codes, a rest and a final mark
    writeMel(5, nw(0, 1, 1));
    writeMel(6, nw(0, 0, 15));
    writeMel(7, nw(0, 2, 2));
    writeMel(8, nw(1, 0, 3));
    writeMel(20, nw(0, 7, 4));
    writeMel(21, nw(1, 3, 0));
    writeMel(30, nw(0, 1, 15));
    writeMel(31, nw(1, 0, 2));
    writeMel(78, nw(0, 0, 2));
    writeMel(79, nw(0, 1, 1));
    writeMel(0, nw(1, 0, 3));
    writeMel(90, nw(1, 7, 7));  // out of range, ignored
    @(negedge clk);
    speedSel = 2'd1;
    startTune(5, 70, "R2");
    idleFor(4, "R9");
    speedSel = 2'd2;
    startTune(5, 40, "R3");
    tempoSel = 1'b1; speedSel = 2'd3;
    startTune(5, 30, "R3");
    tempoSel = 1'b0; speedSel = 2'd1;
    startTune(20, 110, "R4");
    startTune(30, 30, "R5");
    startTune(78, 50, "R8");
    startTune(100, 15, "R7");
    repeatEn = 1'b1;
    startTune(20, 250, "R10");
    stopFor(10, "R12");
    repeatEn = 1'b0;
    startTune(5, 21, "R11");
    startTune(20, 110, "R11");
    stopFor(6, "R12");
    speedSel = 2'd0;
    startTune(31, 70, "R3");
    speedSel = 2'd1;
    idleFor(3, "R1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule